// File: doc/BRIEF.md
# Edge-Timestamp Capture Unit

This block records the time at which an external event occurs. A free-running count arrives on an input bus. One of two event sources is watched: an external pin or the output of an on-chip comparator. The chosen source passes through a synchronizer and an optional glitch filter, then reaches an edge detector that can be set to react to rising or to falling transitions. On a qualifying edge the present count is latched into a capture register and a sticky event flag is raised. Software clears the flag by writing a one.

Each source has its own two-stage synchronizer, and the selection is made after the synchronizers. This means a change of source takes effect at once, but it can present a level step to the edge detector. Software therefore clears the flag right after switching. The filter runs on the system clock. It only passes a new level once four successive samples agree, which costs exactly four extra cycles of latency. A disable input stops any capture while the capture register is being used as the counter's period value.

Top module: `input_capture_unit`

## Requirements
- R1: After reset the capture value reads 0 and the flag reads 0. Reset adopts the current synchronized level, so a source that is already high (or low) during reset produces no capture once reset is released.
- R2: `src_sel_i` = 0 watches `pin_i` and `src_sel_i` = 1 watches `cmp_i`. Transitions on the unselected input have no effect on the capture value or the flag.
- R3: `edge_rise_i` = 1 captures on a low-to-high transition of the watched level and `edge_rise_i` = 0 captures on a high-to-low transition. The opposite transition is ignored.
- R4: With the filter off, a new input level first present at rising clock edge k causes the capture register to load the `count_i` value present at edge k+2, and it is readable after that edge.
- R5: With `filt_en_i` = 1, the capture comes exactly four cycles later than in R4, at edge k+6. A level that lasts three clock cycles or fewer never produces a capture, and a level that lasts four cycles does.
- R6: A capture sets `flag_o` on the next cycle. A cycle with `flag_clr_i` = 1 and no capture clears it. When a capture and a clear fall in the same cycle, the flag ends up set.
- R7: A new capture overwrites the capture value even if the flag is still set. Without a capture the value holds.
- R8: While `trig_dis_i` = 1 no edge causes a capture, and neither the capture value nor the flag changes.
- R9: Changing `src_sel_i` while the two inputs differ acts as an edge of the new level. With the filter off it captures the count at the edge at which the new selection is first present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CNT_W | Free-running counter value to be timestamped |
| pin_i | input | 1 | External event pin (asynchronous) |
| cmp_i | input | 1 | Internal comparator output (asynchronous) |
| src_sel_i | input | 1 | Source select: 0 pin, 1 comparator |
| filt_en_i | input | 1 | Enables the four-sample glitch filter |
| edge_rise_i | input | 1 | 1 rising-edge capture, 0 falling-edge capture |
| trig_dis_i | input | 1 | Suppresses capture while the register serves as the period value |
| flag_clr_i | input | 1 | Write-one strobe that clears the event flag |
| capture_o | output | CNT_W | Latched timestamp |
| flag_o | output | 1 | Sticky capture-event flag |

## Verification
A fresh capture and the software clear of the flag can meet in the same clock cycle. The bench provokes this by timing the clear strobe to the exact edge at which the capture lands, counted from the latency rule. It then expects the flag still set and the new timestamp loaded. A second collision comes from switching the source, which raises an edge in the same cycle as the selection change. The bench judges that case against the count present at that edge. A randomized phase mixes clears, source switches, filter toggles and disables against a cycle model, so the collisions also occur unplanned.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int FILT_TAPS   = 4;
    localparam int NUM_SRC     = 2;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } src_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } trig_t;

    function automatic logic taps_agree(input logic [FILT_TAPS-1:0] taps);
        return (&taps) | ~(|taps);
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [FILT_TAPS-1:0] taps;
    logic                 held;
    logic                 voted;

    assign voted = taps_agree(taps) ? taps[0] : held;
    assign q     = en ? voted : d;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= {FILT_TAPS{d}};
            held <= d;
        end else begin
            taps <= {taps[FILT_TAPS-2:0], d};
            held <= voted;
        end
    end
endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level,
    output trig_t trig
);
    logic prev;

    always_ff @(posedge clk) begin
        prev <= level;
    end

    always_comb begin
        trig.level = level;
        trig.rise  = ~rst & level & ~prev;
        trig.fall  = ~rst & ~level & prev;
    end
endmodule

// File: rtl/input_capture_unit.sv
module input_capture_unit
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic             cmp_i,
    input  logic             src_sel_i,
    input  logic             filt_en_i,
    input  logic             edge_rise_i,
    input  logic             trig_dis_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] capture_o,
    output logic             flag_o
);
    logic [NUM_SRC-1:0] raw_src;
    logic [NUM_SRC-1:0] sync_src;
    logic               sel_level;
    logic               clean_level;
    trig_t              trig;
    logic               cap_fire;
    src_e               src;

    assign raw_src = {cmp_i, pin_i};
    assign src     = src_e'(src_sel_i);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .d   (raw_src[g]),
            .q   (sync_src[g])
        );
    end

    assign sel_level = (src == SRC_CMP) ? sync_src[1] : sync_src[0];

    cap_filter u_filt (
        .clk (clk),
        .rst (rst),
        .en  (filt_en_i),
        .d   (sel_level),
        .q   (clean_level)
    );

    cap_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (clean_level),
        .trig  (trig)
    );

    assign cap_fire = ~trig_dis_i & (edge_rise_i ? trig.rise : trig.fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            capture_o <= '0;
            flag_o    <= 1'b0;
        end else begin
            if (cap_fire) begin
                capture_o <= count_i;
            end
            if (cap_fire) begin
                flag_o <= 1'b1;
            end else if (flag_clr_i) begin
                flag_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_i,
    input logic             trig_dis_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] capture_o,
    input logic             flag_o,
    input logic             cap_fire
);
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> flag_o);

    a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !cap_fire) |=> !flag_o);

    a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (!flag_clr_i && !cap_fire) |=> $stable(flag_o));

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> (capture_o == $past(count_i)));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !cap_fire |=> $stable(capture_o));

    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        trig_dis_i |-> !cap_fire);
endmodule

bind input_capture_unit cap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count_i    (count_i),
    .trig_dis_i (trig_dis_i),
    .flag_clr_i (flag_clr_i),
    .capture_o  (capture_o),
    .flag_o     (flag_o),
    .cap_fire   (cap_fire)
);

// File: tb/input_capture_unit_test.sv
`timescale 1ns/1ps
module input_capture_unit_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] count_i = '0;
    logic             pin_i = 1'b1;
    logic             cmp_i = 1'b0;
    logic             src_sel_i = 1'b0;
    logic             filt_en_i = 1'b0;
    logic             edge_rise_i = 1'b1;
    logic             trig_dis_i = 1'b0;
    logic             flag_clr_i = 1'b0;
    logic [CNT_W-1:0] capture_o;
    logic             flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) count_i <= count_i + 16'd1;

    input_capture_unit #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .count_i(count_i), .pin_i(pin_i), .cmp_i(cmp_i),
        .src_sel_i(src_sel_i), .filt_en_i(filt_en_i), .edge_rise_i(edge_rise_i),
        .trig_dis_i(trig_dis_i), .flag_clr_i(flag_clr_i),
        .capture_o(capture_o), .flag_o(flag_o)
    );

    // cycle model built from the requirements' timing rules
    logic       mp1, mp2, mc1, mc2, m_hold, m_prev, m_flag;
    logic [3:0] m_taps;
    logic [15:0] m_cap;

    function automatic logic pick_level(input logic s, input logic p, input logic c);
        return s ? c : p;
    endfunction

    always @(posedge clk) begin
        logic lv, vote, lvl, fire;
        lv = pick_level(src_sel_i, mp2, mc2);
        if (rst) begin
            m_taps = {4{lv}}; m_hold = lv; m_prev = lv; m_cap = '0; m_flag = 1'b0;
        end else begin
            vote = ((&m_taps) || !(|m_taps)) ? m_taps[0] : m_hold;
            lvl  = filt_en_i ? vote : lv;
            fire = !trig_dis_i && (edge_rise_i ? (lvl && !m_prev) : (!lvl && m_prev));
            if (fire) m_cap = count_i;
            m_flag = fire ? 1'b1 : (flag_clr_i ? 1'b0 : m_flag);
            m_prev = lvl; m_hold = vote; m_taps = {m_taps[2:0], lv};
        end
        mp2 = mp1; mp1 = pin_i; mc2 = mc1; mc1 = cmp_i;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0; step(1);
    endtask

    logic [15:0] v, v2;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        step(6);
        rst = 1'b0;
        step(8);
        // R1: source high through reset gives no capture
        chk("R1 capture after reset", capture_o, 0);
        chk("R1 flag after reset", flag_o, 0);

        // R3: falling edge ignored in rising mode
        pin_i = 1'b0; step(8);
        chk("R3 falling ignored in rise mode", flag_o, 0);

        // R4: filter-off latency
        pin_i = 1'b1; v = count_i; step(8);
        chk("R4 capture value filter off", capture_o, v + 16'd2);
        chk("R6 flag set on capture", flag_o, 1);
        clear_flag();
        chk("R6 write-one clears flag", flag_o, 0);

        // R5: filter-on latency
        filt_en_i = 1'b1; step(4);
        pin_i = 1'b0; step(10);
        pin_i = 1'b1; v = count_i; step(12);
        chk("R5 capture value filter on", capture_o, v + 16'd6);
        clear_flag();

        // R5: three-cycle pulse rejected, four-cycle pulse accepted
        pin_i = 1'b0; step(10); clear_flag();
        v2 = capture_o;
        pin_i = 1'b1; step(3); pin_i = 1'b0; step(12);
        chk("R5 short pulse flag", flag_o, 0);
        chk("R5 short pulse value", capture_o, v2);
        pin_i = 1'b1; v = count_i; step(4); pin_i = 1'b0; step(12);
        chk("R5 four-cycle pulse value", capture_o, v + 16'd6);
        chk("R5 four-cycle pulse flag", flag_o, 1);

        // R3: falling mode, filter off
        filt_en_i = 1'b0; edge_rise_i = 1'b0; step(4); clear_flag();
        pin_i = 1'b1; step(6);
        chk("R3 rising ignored in fall mode", flag_o, 0);
        pin_i = 1'b0; v = count_i; step(6);
        chk("R3 falling capture value", capture_o, v + 16'd2);

        // R7: overwrite with flag still set
        pin_i = 1'b1; step(5);
        pin_i = 1'b0; v2 = count_i; step(6);
        chk("R7 overwrite value", capture_o, v2 + 16'd2);
        chk("R7 flag still set", flag_o, 1);

        // R6: clear and capture in the same cycle
        clear_flag();
        pin_i = 1'b1; step(5);
        pin_i = 1'b0; v = count_i; step(2);
        flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
        chk("R6 set wins over clear", flag_o, 1);
        chk("R6 collision value", capture_o, v + 16'd2);
        clear_flag();

        // R8: disable suppresses capture
        trig_dis_i = 1'b1;
        v2 = capture_o;
        pin_i = 1'b1; step(5); pin_i = 1'b0; step(6);
        chk("R8 disabled flag", flag_o, 0);
        chk("R8 disabled value", capture_o, v2);
        trig_dis_i = 1'b0; step(2);

        // R2: unselected comparator ignored
        edge_rise_i = 1'b1; step(2);
        cmp_i = 1'b1; step(6);
        chk("R2 unselected input ignored", flag_o, 0);

        // R9: switching source with differing levels captures
        src_sel_i = 1'b1; v = count_i; step(3);
        chk("R9 source switch value", capture_o, v);
        chk("R9 source switch flag", flag_o, 1);
        clear_flag();

        // R2: comparator now drives, pin ignored
        pin_i = 1'b1; step(6);
        chk("R2 pin ignored when comparator selected", flag_o, 0);
        cmp_i = 1'b0; step(6);
        cmp_i = 1'b1; v = count_i; step(6);
        chk("R2 comparator capture value", capture_o, v + 16'd2);

        // randomized phase against the cycle model (R2..R8)
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R7 random capture value", capture_o, m_cap);
            chk("R6 random flag", flag_o, m_flag);
            if ($urandom % 6 == 0) pin_i = ~pin_i;
            if ($urandom % 7 == 0) cmp_i = ~cmp_i;
            if ($urandom % 97 == 0) src_sel_i = ~src_sel_i;
            if ($urandom % 89 == 0) filt_en_i = ~filt_en_i;
            if ($urandom % 83 == 0) edge_rise_i = ~edge_rise_i;
            if ($urandom % 71 == 0) trig_dis_i = ~trig_dis_i;
            flag_clr_i = ($urandom % 5 == 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule